// File: doc/BRIEF.md
# Gate and Fast-Clear Sequencer

This block is the digital control for a multichannel charge-integrating front end. It picks one of two external gate lines, adds a software test gate on top of it, and drives an integrate-enable output that tells the analog side when to collect charge. It also combines several clear requests into one. A clear that lasts long enough throws away the event in progress and makes the block busy for a programmed recovery interval. During that interval no gate reaches the integrator.

Two indicator outputs are stretched so that a short gate, or a short bus selection, stays visible long enough to see. The external gate and clear inputs are asynchronous and pass through two-flop synchronizers inside the block. The gate-source select bit, the clear register bit, the test-gate strobe and the slave-selected flag come from logic already running on the block's clock, so they are used as they arrive.

Top module: `gate_clear_seq`

## Requirements
- R1: The clear request is the OR of `fp_clear`, `bus_clear` and `clr_reg_bit`. Any one of them alone can start a clear.
- R2: A clear counts only after the merged request has been high for at least `CLR_MIN_CYC` consecutive cycles, as seen after synchronization. A shorter request leaves `busy` and `event_discard` low.
- R3: Each qualified clear raises `event_discard` for exactly one cycle, however long the request stays high. For a clear from `fp_clear` or `bus_clear`, this happens `CLR_MIN_CYC`+2 cycles after the input rises.
- R4: `busy` rises in the same cycle as `event_discard` and stays high while the request is high. It falls `HOLDOFF_CYC` cycles after the synchronized request falls. A new qualified clear during the recovery interval keeps `busy` high without a gap and restarts the interval.
- R5: With `gate_src_sel` at 0 the gate comes from `fp_gate`. With `gate_src_sel` at 1 it comes from `bus_gate`. The unselected line has no effect on `integrate`. A gate on the selected line gives an `integrate` pulse of the same length, 3 cycles later.
- R6: A one-cycle `test_gate_wr` strobe gives an `integrate` pulse of `TEST_GATE_CYC` cycles, starting 2 cycles after the strobe. This pulse is ORed with the selected gate line.
- R7: While the selected gate line is held high, `integrate` stays high without a break, so a test gate is not visible.
- R8: While `busy` is high, `integrate` is forced low in the following cycle, whatever the gate inputs are doing.
- R9: `gate_led` rises 1 cycle after `integrate` rises. It stays high until `LED_HOLD_CYC` cycles after `integrate` falls.
- R10: `addr_led` rises 1 cycle after `slave_sel` rises. It stays high until `LED_HOLD_CYC` cycles after `slave_sel` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp_gate | input | 1 | Front-panel gate, asynchronous |
| bus_gate | input | 1 | Bus trigger gate line, asynchronous |
| gate_src_sel | input | 1 | Gate source select: 0 selects the front panel, 1 selects the bus line |
| test_gate_wr | input | 1 | One-cycle strobe that fires a test gate |
| fp_clear | input | 1 | Front-panel clear, asynchronous |
| bus_clear | input | 1 | Bus trigger clear line, asynchronous |
| clr_reg_bit | input | 1 | Software clear bit (level) |
| slave_sel | input | 1 | Module is selected on the bus |
| integrate | output | 1 | Integrate enable to the analog front end |
| event_discard | output | 1 | One-cycle pulse that throws away the current event |
| busy | output | 1 | Clear and recovery in progress |
| gate_led | output | 1 | Stretched gate indicator |
| addr_led | output | 1 | Stretched selection indicator |

## Verification
The hardest state to reach is a second clear that qualifies while the recovery interval of the first is still running. The stimulus has to time the second request so that it rises after the first request has fallen, and then hold it long enough to qualify. A directed case does this with two clear pulses on different sources and checks that `busy` stays high without a gap until the second interval ends. Random clear widths are drawn around the qualification threshold on all three sources, so both sides of the width limit are exercised.

// File: rtl/gate_clear_seq.sv
module gate_clear_seq #(
  parameter int CLR_MIN_CYC   = 20,
  parameter int HOLDOFF_CYC   = 40,
  parameter int TEST_GATE_CYC = 8,
  parameter int LED_HOLD_CYC  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fp_gate,
  input  logic bus_gate,
  input  logic gate_src_sel,
  input  logic test_gate_wr,
  input  logic fp_clear,
  input  logic bus_clear,
  input  logic clr_reg_bit,
  input  logic slave_sel,
  output logic integrate,
  output logic event_discard,
  output logic busy,
  output logic gate_led,
  output logic addr_led
);
  localparam int WW = $clog2(CLR_MIN_CYC + 1);
  localparam int HW = $clog2(HOLDOFF_CYC + 1);
  localparam int TW = $clog2(TEST_GATE_CYC + 1);
  localparam int LW = $clog2(LED_HOLD_CYC + 1);

  logic [3:0] sy1, sy2;
  logic [WW-1:0] wcnt;
  logic [HW-1:0] hcnt;
  logic [TW-1:0] tcnt;
  logic clr_req, qual, sel_gate;
  logic [1:0] led_trig, led_q;
  logic [LW-1:0] lcnt [2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= {bus_clear, fp_clear, bus_gate, fp_gate};
      sy2 <= sy1;
    end

  assign clr_req  = sy2[2] | sy2[3] | clr_reg_bit;
  assign qual     = clr_req && (wcnt == WW'(CLR_MIN_CYC - 1));
  assign sel_gate = gate_src_sel ? sy2[1] : sy2[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        wcnt <= '0;
    else if (!clr_req)                 wcnt <= '0;
    else if (wcnt != WW'(CLR_MIN_CYC)) wcnt <= wcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy          <= 1'b0;
      hcnt          <= '0;
      event_discard <= 1'b0;
    end else begin
      event_discard <= qual;
      if (qual) begin
        busy <= 1'b1;
        hcnt <= '0;
      end else if (busy) begin
        if (clr_req) hcnt <= '0;
        else if (hcnt == HW'(HOLDOFF_CYC - 1)) begin
          busy <= 1'b0;
          hcnt <= '0;
        end else hcnt <= hcnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            tcnt <= '0;
    else if (test_gate_wr) tcnt <= TW'(TEST_GATE_CYC);
    else if (tcnt != '0)   tcnt <= tcnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) integrate <= 1'b0;
    else        integrate <= (sel_gate | (tcnt != '0)) & ~busy;

  assign led_trig = {slave_sel, integrate};

  for (genvar i = 0; i < 2; i++) begin : g_led
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)               lcnt[i] <= '0;
      else if (led_trig[i])     lcnt[i] <= LW'(LED_HOLD_CYC);
      else if (lcnt[i] != '0)   lcnt[i] <= lcnt[i] - 1'b1;
    assign led_q[i] = lcnt[i] != '0;
  end

  assign gate_led = led_q[0];
  assign addr_led = led_q[1];
endmodule

module gate_clear_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic clr_req,
  input logic test_gate_wr,
  input logic slave_sel,
  input logic integrate,
  input logic event_discard,
  input logic busy,
  input logic gate_led,
  input logic addr_led
);
  AST_DISCARD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    event_discard |=> !event_discard); // R3
  AST_DISCARD_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    event_discard |-> busy); // R4
  AST_BUSY_HELD_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && clr_req) |=> busy); // R4
  AST_MASK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !integrate); // R8
  AST_TEST_GATE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (test_gate_wr ##1 !busy) |=> integrate); // R6
  AST_GATE_LED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    integrate |=> gate_led); // R9
  AST_ADDR_LED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    slave_sel |=> addr_led); // R10
endmodule

bind gate_clear_seq gate_clear_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .test_gate_wr(test_gate_wr),
  .slave_sel(slave_sel), .integrate(integrate), .event_discard(event_discard),
  .busy(busy), .gate_led(gate_led), .addr_led(addr_led)
);

// File: tb/test_gate_clear_seq.sv
`timescale 1ns/1ps
module test_gate_clear_seq;
  localparam int MIN  = 20;
  localparam int HOLD = 40;
  localparam int TG   = 8;
  localparam int LH   = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fp_gate = 0, bus_gate = 0, gate_src_sel = 0, test_gate_wr = 0;
  logic fp_clear = 0, bus_clear = 0, clr_reg_bit = 0, slave_sel = 0;
  logic integrate, event_discard, busy, gate_led, addr_led;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  gate_clear_seq #(.CLR_MIN_CYC(MIN), .HOLDOFF_CYC(HOLD), .TEST_GATE_CYC(TG),
                   .LED_HOLD_CYC(LH)) i_gate_clear_seq (
    .clk(clk), .rst_n(rst_n), .fp_gate(fp_gate), .bus_gate(bus_gate),
    .gate_src_sel(gate_src_sel), .test_gate_wr(test_gate_wr),
    .fp_clear(fp_clear), .bus_clear(bus_clear), .clr_reg_bit(clr_reg_bit),
    .slave_sel(slave_sel), .integrate(integrate), .event_discard(event_discard),
    .busy(busy), .gate_led(gate_led), .addr_led(addr_led));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic set_clr(int src, logic v);
    case (src)
      0: fp_clear = v;
      1: bus_clear = v;
      default: clr_reg_bit = v;
    endcase
  endtask

  function automatic int exp_busy(int w);
    return (w >= MIN) ? w + HOLD - MIN : 0;
  endfunction

  function automatic int exp_first(int src);
    return (src == 2) ? MIN : MIN + 2;
  endfunction

  // two clear pulses: first from negedge 0 for w1 cycles, second from negedge a2 for w2 cycles
  task automatic clr_run(int s1, int w1, int s2, int a2, int w2,
                         output int first, output int nb, output int nd, output int last);
    int span;
    first = -1; nb = 0; nd = 0; last = -1;
    span = ((w2 > 0) ? a2 + w2 : w1) + HOLD + 10;
    @(negedge clk);
    set_clr(s1, 1'b1);
    for (int j = 1; j <= span; j++) begin
      @(negedge clk);
      if (busy) begin
        nb++;
        last = j;
        if (first < 0) first = j;
      end
      if (event_discard) nd++;
      if (j == w1) set_clr(s1, 1'b0);
      if (w2 > 0 && j == a2) set_clr(s2, 1'b1);
      if (w2 > 0 && j == a2 + w2) set_clr(s2, 1'b0);
    end
  endtask

  task automatic gate_run(logic sel, int src, int w, output int first, output int n,
                          output int lfirst, output int ln);
    first = -1; n = 0; lfirst = -1; ln = 0;
    @(negedge clk);
    gate_src_sel = sel;
    repeat (4) @(negedge clk);
    if (src == 0) fp_gate = 1; else bus_gate = 1;
    for (int j = 1; j <= w + LH + 8; j++) begin
      @(negedge clk);
      if (integrate) begin n++; if (first < 0) first = j; end
      if (gate_led) begin ln++; if (lfirst < 0) lfirst = j; end
      if (j == w) begin fp_gate = 0; bus_gate = 0; end
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f, nb, nd, last, n, lf, ln, w, s;
    void'($urandom(32'h5eed_1881));
    #1;
    chk("reset integrate", integrate, 0);
    chk("reset busy", busy, 0);
    chk("reset discard", event_discard, 0);
    chk("reset leds", gate_led + addr_led, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 R2 R3 R4 directed: each source exactly at threshold and one short
    for (int src = 0; src < 3; src++) begin
      clr_run(src, MIN, 0, 0, 0, f, nb, nd, last);
      chk("R1 source start", f, exp_first(src));
      chk("R4 busy length", nb, exp_busy(MIN));
      chk("R3 one discard", nd, 1);
      clr_run(src, MIN - 1, 0, 0, 0, f, nb, nd, last);
      chk("R2 short clear no busy", nb, 0);
      chk("R2 short clear no discard", nd, 0);
    end

    // R3 long clear: single discard
    clr_run(0, MIN + 30, 0, 0, 0, f, nb, nd, last);
    chk("R3 long clear one discard", nd, 1);
    chk("R4 long clear busy", nb, exp_busy(MIN + 30));

    // R4 restart during recovery
    clr_run(0, MIN + 2, 1, MIN + 12, MIN + 4, f, nb, nd, last);
    chk("R4 restart no gap", nb, last - f + 1);
    chk("R4 restart end", last, (MIN + 12) + (MIN + 4) + 1 + HOLD);
    chk("R3 restart two discards", nd, 2);

    // R2 R4 random widths around threshold
    for (int k = 0; k < 14; k++) begin
      w = MIN - 3 + int'($urandom % 8);
      s = int'($urandom % 3);
      clr_run(s, w, 0, 0, 0, f, nb, nd, last);
      chk("R2 random width busy", nb, exp_busy(w));
      chk("R3 random width discard", nd, (w >= MIN) ? 1 : 0);
    end

    // R5 selection, R9 led
    gate_run(0, 0, 4, f, n, lf, ln);
    chk("R5 fp selected width", n, 4);
    chk("R5 fp selected latency", f, 3);
    chk("R9 led length", ln, 4 + LH - 1);
    chk("R9 led start", lf, 4);
    gate_run(1, 1, 6, f, n, lf, ln);
    chk("R5 bus selected width", n, 6);
    gate_run(1, 0, 6, f, n, lf, ln);
    chk("R5 unselected fp ignored", n, 0);
    gate_run(0, 1, 6, f, n, lf, ln);
    chk("R5 unselected bus ignored", n, 0);
    for (int k = 0; k < 8; k++) begin
      logic sl;
      int sr;
      sl = logic'($urandom % 2);
      sr = int'($urandom % 2);
      w = 1 + int'($urandom % 12);
      gate_run(sl, sr, w, f, n, lf, ln);
      chk("R5 random gate", n, (sr == int'(sl)) ? w : 0);
      chk("R9 random led", ln, (sr == int'(sl)) ? w + LH - 1 : 0);
    end

    // R6 test gate
    @(negedge clk);
    gate_src_sel = 0;
    repeat (LH + 4) @(negedge clk);
    test_gate_wr = 1;
    f = -1; n = 0;
    for (int j = 1; j <= TG + 6; j++) begin
      @(negedge clk);
      if (j == 1) test_gate_wr = 0;
      if (integrate) begin n++; if (f < 0) f = j; end
    end
    chk("R6 test gate width", n, TG);
    chk("R6 test gate latency", f, 2);

    // R7 stuck-high selected source hides test gate
    fp_gate = 1;
    repeat (6) @(negedge clk);
    test_gate_wr = 1;
    n = 0;
    for (int j = 1; j <= TG + 10; j++) begin
      @(negedge clk);
      if (j == 1) test_gate_wr = 0;
      if (!integrate) n++;
    end
    chk("R7 no break while stuck", n, 0);
    fp_gate = 0;
    repeat (6) @(negedge clk);
    chk("R7 released", integrate, 0);

    // R8 masking during busy
    fp_clear = 1;
    repeat (MIN + 4) @(negedge clk);
    chk("R8 busy up", busy, 1);
    fp_gate = 1;
    test_gate_wr = 1;
    @(negedge clk);
    test_gate_wr = 0;
    n = 0;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (integrate) n++;
    end
    chk("R8 gate masked", n, 0);
    fp_gate = 0;
    fp_clear = 0;
    repeat (HOLD + 6) @(negedge clk);
    chk("R8 busy done", busy, 0);
    test_gate_wr = 1;
    @(negedge clk);
    test_gate_wr = 0;
    @(negedge clk);
    chk("R8 gate after busy", integrate, 1);
    repeat (LH + TG) @(negedge clk);

    // R10 address led
    slave_sel = 1;
    f = -1; n = 0;
    for (int j = 1; j <= 3 + LH + 6; j++) begin
      @(negedge clk);
      if (addr_led) begin n++; if (f < 0) f = j; end
      if (j == 3) slave_sel = 0;
    end
    chk("R10 addr led start", f, 1);
    chk("R10 addr led length", n, 3 + LH - 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule